// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Readout Controller

This block is the host side of a three-wire link to a converter that samples two differential channels at the same instant. From the system clock it derives a serial clock and a convert strobe. It shifts in one 32-clock frame per strobe and splits that frame into two signed words. Each frame returns the results of the conversion started by the strobe before it. For that reason the first frame after reset, and the first frame after a low-power period, produce no result.

A single frame is started with a one-cycle start request. A level on the run input keeps frames going back to back. The controller can also put the converter into a light or a deep low-power state. It does this by sending two or four strobes while the serial clock stays still. A wake request sends one serial-clock pulse. After a deep state, conversions are held off for a set number of system clocks so the converter's reference can settle.

Top module: `adc_rd_ctrl`

## Requirements
- R1: Out of reset, conv_o, sck_o and valid_o are low, both result words are zero, idle_o is high and lowpwr_o is low.
- R2: A frame raises conv_o while sck_o is low. The first sck_o rising edge follows SCK_HALF system clocks later. conv_o stays high for 2*SCK_HALF clocks. sck_o then gives FRAME_EDGES rising edges, each high and low for SCK_HALF clocks.
- R3: The serial input is sampled on every sck_o rising edge, with edges numbered 1 to 32 from the strobe. With RES_BITS=14, channel 0 is taken MSB first from edges 3..16 and channel 1 from edges 19..32.
- R4: With RES_BITS=12, channel 0 is taken from edges 3..14 and channel 1 from edges 19..30. The two bits that follow each word are discarded. The strobe and clock timing is the same as with 14 bits.
- R5: Each word is two's complement and is sign-extended to OUT_W=16 bits.
- R6: valid_o is high for exactly one system clock, the same cycle in which sck_o first shows its 32nd rising edge. Both words change only at such a pulse.
- R7: The first frame after reset, and the first frame after a wake, give no valid_o pulse and leave the words unchanged.
- R8: While run_i is high, the next strobe rises (2*(FRAME_EDGES-32)+1)*SCK_HALF system clocks after the 32nd sck_o rising edge, with no idle gap.
- R9: nap_req_i in idle gives exactly two conv_o pulses, each SCK_HALF clocks high. sck_o stays low throughout, and then lowpwr_o stays high.
- R10: sleep_req_i in idle gives exactly four such pulses. It wins over nap_req_i when both are present.
- R11: wake_req_i while dormant gives one sck_o pulse with conv_o low. lowpwr_o then falls after 2*SCK_HALF clocks from a light state, or after 2*SCK_HALF+SETTLE_CYCLES clocks from a deep state.
- R12: start_i and run_i do nothing while lowpwr_o is high, and wake_req_i does nothing in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one frame |
| run_i | input | 1 | Keep frames running back to back |
| nap_req_i | input | 1 | Request the light low-power state |
| sleep_req_i | input | 1 | Request the deep low-power state |
| wake_req_i | input | 1 | Wake the converter |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| ch0_o | output | 16 | Channel 0 result, sign-extended |
| ch1_o | output | 16 | Channel 1 result, sign-extended |
| valid_o | output | 1 | One-cycle pulse when both words are new |
| idle_o | output | 1 | Controller ready for a request |
| lowpwr_o | output | 1 | Converter entering, in, or leaving low power |

## Verification
The case hardest to reach from the ports is a start request that lands during the settling hold-off after a deep wake. At that point no strobe may appear, and the next frame must still yield no result. The stimulus sends a combined sleep and nap request, wakes the converter, and pulses start_i partway through the hold-off. It then counts strobes and lowpwr_o cycles until idle returns. A second instance built for 12-bit words shares the same serial input. The patterns put distinct values in the discarded bit positions, so a wrong slice shows up in the results.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Frame layout as seen from the strobe: edge numbers are behavioural.
    localparam int SAMPLE_EDGES   = 32;
    localparam int CH0_FIRST_EDGE = 3;
    localparam int CH1_FIRST_EDGE = 19;

    // Strobe counts that select the low-power depth.
    localparam int NAP_PULSES     = 2;
    localparam int SLEEP_PULSES   = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FRAME  = 3'd1,
        ST_PWR    = 3'd2,
        ST_DOWN   = 3'd3,
        ST_WAKE   = 3'd4,
        ST_SETTLE = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(SCK_HALF - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_rd_settle.sv
module adc_rd_settle #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_rd_unpack.sv
module adc_rd_unpack
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS = 14,
    parameter int OUT_W    = 16
) (
    input  logic [SAMPLE_EDGES-1:0]  word_i,
    output logic [1:0][OUT_W-1:0]    chan_o
);
    // Bit for edge k sits at word_i[SAMPLE_EDGES-k].
    logic [SAMPLE_EDGES-1:0] unused_word;
    assign unused_word = word_i;

    for (genvar g = 0; g < 2; g++) begin : g_ch
        localparam int TOP = SAMPLE_EDGES - ((g == 0) ? CH0_FIRST_EDGE : CH1_FIRST_EDGE);
        logic [RES_BITS-1:0] raw;
        assign raw       = word_i[TOP -: RES_BITS];
        assign chan_o[g] = {{(OUT_W - RES_BITS){raw[RES_BITS-1]}}, raw};
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int SCK_HALF      = 2,
    parameter int RES_BITS      = 14,
    parameter int FRAME_EDGES   = 34,
    parameter int SETTLE_CYCLES = 250000,
    parameter int OUT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             nap_req_i,
    input  logic             sleep_req_i,
    input  logic             wake_req_i,
    input  logic             sdo_i,
    output logic             conv_o,
    output logic             sck_o,
    output logic [OUT_W-1:0] ch0_o,
    output logic [OUT_W-1:0] ch1_o,
    output logic             valid_o,
    output logic             idle_o,
    output logic             lowpwr_o
);
    localparam int HP_W      = $clog2(2 * FRAME_EDGES);
    localparam int HP_END    = 2 * FRAME_EDGES - 1;
    localparam int HP_LASTB  = 2 * SAMPLE_EDGES - 1;
    localparam int NAP_END   = 2 * NAP_PULSES - 1;
    localparam int SLP_END   = 2 * SLEEP_PULSES - 1;
    localparam int SR_W      = SAMPLE_EDGES - 1;

    typedef struct packed {
        ctl_state_e       st;
        logic [HP_W-1:0]  hp;
        logic             conv;
        logic             sck;
        logic [SR_W-1:0]  sr;
        logic [OUT_W-1:0] ch0;
        logic [OUT_W-1:0] ch1;
        logic             valid;
        logic             primed;
        logic             deep;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic                   tick;
    logic                   div_en;
    logic                   load_settle;
    logic                   settle_done;
    logic [HP_W-1:0]        hp_inc;
    logic [1:0][OUT_W-1:0]  chan;
    logic                   dormant_w;
    logic                   settling_w;

    assign div_en = (r_q.st == ST_FRAME) || (r_q.st == ST_PWR) || (r_q.st == ST_WAKE);

    adc_rd_clkdiv #(.SCK_HALF(SCK_HALF)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (div_en),
        .tick_o (tick)
    );

    adc_rd_settle #(.CYCLES(SETTLE_CYCLES)) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_settle),
        .done_o (settle_done)
    );

    adc_rd_unpack #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) unpack_i (
        .word_i ({r_q.sr, sdo_i}),
        .chan_o (chan)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        load_settle = 1'b0;
        hp_inc      = r_q.hp + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (sleep_req_i || nap_req_i) begin
                    r_d.st     = ST_PWR;
                    r_d.deep   = sleep_req_i;
                    r_d.hp     = '0;
                    r_d.conv   = 1'b1;
                    r_d.primed = 1'b0;
                end else if (start_i || run_i) begin
                    r_d.st   = ST_FRAME;
                    r_d.hp   = '0;
                    r_d.conv = 1'b1;
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (r_q.hp == HP_W'(HP_END)) begin
                        r_d.sck = 1'b0;
                        r_d.hp  = '0;
                        if (run_i) begin
                            r_d.conv = 1'b1;
                        end else begin
                            r_d.conv = 1'b0;
                            r_d.st   = ST_IDLE;
                        end
                    end else begin
                        r_d.hp   = hp_inc;
                        r_d.sck  = hp_inc[0];
                        r_d.conv = (hp_inc == HP_W'(1));
                        if (hp_inc[0]) begin
                            r_d.sr = {r_q.sr[SR_W-2:0], sdo_i};
                            if (hp_inc == HP_W'(HP_LASTB)) begin
                                if (r_q.primed) begin
                                    r_d.ch0   = chan[0];
                                    r_d.ch1   = chan[1];
                                    r_d.valid = 1'b1;
                                end
                                r_d.primed = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_PWR: begin
                if (tick) begin
                    if (r_q.hp == (r_q.deep ? HP_W'(SLP_END) : HP_W'(NAP_END))) begin
                        r_d.st   = ST_DOWN;
                        r_d.conv = 1'b0;
                        r_d.hp   = '0;
                    end else begin
                        r_d.hp   = hp_inc;
                        r_d.conv = ~hp_inc[0];
                    end
                end
            end
            ST_DOWN: begin
                if (wake_req_i) begin
                    r_d.st  = ST_WAKE;
                    r_d.sck = 1'b1;
                    r_d.hp  = '0;
                end
            end
            ST_WAKE: begin
                if (tick) begin
                    if (!r_q.hp[0]) begin
                        r_d.hp  = hp_inc;
                        r_d.sck = 1'b0;
                    end else begin
                        r_d.hp = '0;
                        if (r_q.deep) begin
                            r_d.st      = ST_SETTLE;
                            load_settle = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dormant_w  = (r_q.st == ST_DOWN);
    assign settling_w = (r_q.st == ST_SETTLE);

    assign conv_o   = r_q.conv;
    assign sck_o    = r_q.sck;
    assign ch0_o    = r_q.ch0;
    assign ch1_o    = r_q.ch1;
    assign valid_o  = r_q.valid;
    assign idle_o   = (r_q.st == ST_IDLE);
    assign lowpwr_o = (r_q.st == ST_PWR) || (r_q.st == ST_WAKE) || dormant_w || settling_w;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_o,
    input logic             sck_o,
    input logic             valid_o,
    input logic             idle_o,
    input logic             lowpwr_o,
    input logic             dormant,
    input logic             settling,
    input logic [OUT_W-1:0] ch0_o,
    input logic [OUT_W-1:0] ch1_o
);
    assert_strobe_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> !sck_o);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!sck_o && !conv_o));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(sck_o));

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(ch0_o) && $stable(ch1_o)));

    assert_no_valid_lowpwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_o |-> !valid_o);

    assert_dormant_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dormant |-> (!sck_o && !conv_o));

    assert_settle_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> (!sck_o && !conv_o && lowpwr_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.OUT_W(OUT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_o   (conv_o),
    .sck_o    (sck_o),
    .valid_o  (valid_o),
    .idle_o   (idle_o),
    .lowpwr_o (lowpwr_o),
    .dormant  (dormant_w),
    .settling (settling_w),
    .ch0_o    (ch0_o),
    .ch1_o    (ch1_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
    localparam int HALF   = 2;
    localparam int FE     = 34;
    localparam int SETTLE = 40;
    localparam int NSW    = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, run_i = 1'b0, nap_i = 1'b0, sleep_i = 1'b0, wake_i = 1'b0;
    logic sdo = 1'b0;

    logic conv_o, sck_o, valid_o, idle_o, lowpwr_o;
    logic [15:0] ch0_o, ch1_o;
    logic conv12, sck12, valid12, idle12, lowpwr12;
    logic [15:0] ch0_12, ch1_12;

    always #4 clk = ~clk;

    adc_rd_ctrl #(.SCK_HALF(HALF), .RES_BITS(14), .FRAME_EDGES(FE), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_i), .nap_req_i(nap_i),
        .sleep_req_i(sleep_i), .wake_req_i(wake_i), .sdo_i(sdo), .conv_o(conv_o), .sck_o(sck_o),
        .ch0_o(ch0_o), .ch1_o(ch1_o), .valid_o(valid_o), .idle_o(idle_o), .lowpwr_o(lowpwr_o));

    adc_rd_ctrl #(.SCK_HALF(HALF), .RES_BITS(12), .FRAME_EDGES(FE), .SETTLE_CYCLES(SETTLE)) dut12_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_i), .nap_req_i(nap_i),
        .sleep_req_i(sleep_i), .wake_req_i(wake_i), .sdo_i(sdo), .conv_o(conv12), .sck_o(sck12),
        .ch0_o(ch0_12), .ch1_o(ch1_12), .valid_o(valid12), .idle_o(idle12), .lowpwr_o(lowpwr12));

    int checks = 0, fails = 0;

    task automatic chk_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen(input int i);
        logic [13:0] a, b;
        logic [1:0]  j;
        a = 14'((i * 613 + 8191) & 16383);
        b = 14'(((i * 4093) ^ 5461) & 16383);
        if (i % 8 == 0) begin a = 14'h2000; b = 14'h1FFF; end
        if (i % 8 == 1) begin a = 14'h1FFF; b = 14'h2000; end
        if (i % 8 == 2) begin a = 14'h3FFF; b = 14'h0000; end
        j = 2'(i);
        return {j, a, ~j, b};
    endfunction

    // Converter serial output model: bit for edge k is driven after edge k-1.
    logic [31:0] cur_pat = '0;
    int bitk = 0;
    int frame_no = 0;
    always @(posedge conv_o) begin
        cur_pat = gen(frame_no);
        frame_no++;
        bitk = 0;
        #1 sdo = cur_pat[31];
    end
    always @(posedge sck_o) begin
        bitk++;
        #1 sdo = (bitk < 32) ? cur_pat[31 - bitk] : 1'b0;
    end

    // Port monitor, sampled at the falling clock edge.
    int tcyc = 0, n_conv = 0, n_sck = 0, n_valid = 0, conv_hi = 0, sck_hi = 0;
    int t_conv = -1, t_sck = -1, t_valid = 0, mism = 0;
    bit gap_armed = 0;
    logic conv_p = 1'b0, sck_p = 1'b0;

    always @(negedge clk) begin
        tcyc++;
        if (conv_o && !conv_p) begin
            n_conv++;
            if (t_conv < 0) t_conv = tcyc;
            if (gap_armed) begin
                chk_eq("R8 back-to-back strobe gap", tcyc - t_valid, (2 * (FE - 32) + 1) * HALF);
                gap_armed = 0;
            end
        end
        if (sck_o && !sck_p) begin
            n_sck++;
            if (t_sck < 0) t_sck = tcyc;
        end
        if (conv_o) conv_hi++;
        if (sck_o) sck_hi++;
        if (conv_o != conv12 || sck_o != sck12 || valid_o != valid12) mism++;
        if (valid_o) begin
            n_valid++;
            t_valid = tcyc;
            gap_armed = run_i;
            chk_eq("R6 valid on rising sck", longint'(sck_o && !sck_p), 1);
            chk_eq("R3 R5 ch0 14-bit", ch0_o, {{2{cur_pat[29]}}, cur_pat[29:16]});
            chk_eq("R3 R5 ch1 14-bit", ch1_o, {{2{cur_pat[13]}}, cur_pat[13:0]});
            chk_eq("R4 R5 ch0 12-bit", ch0_12, {{4{cur_pat[29]}}, cur_pat[29:18]});
            chk_eq("R4 R5 ch1 12-bit", ch1_12, {{4{cur_pat[13]}}, cur_pat[13:2]});
        end
        conv_p = conv_o;
        sck_p  = sck_o;
    end

    task automatic clear_mon();
        n_conv = 0; n_sck = 0; n_valid = 0; conv_hi = 0; sck_hi = 0;
        t_conv = -1; t_sck = -1; gap_armed = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!idle_o);
    endtask

    task automatic one_frame();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
    endtask

    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [15:0] held0, held1;
    int cnt;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1 conv", conv_o, 0);
        chk_eq("R1 sck", sck_o, 0);
        chk_eq("R1 valid", valid_o, 0);
        chk_eq("R1 ch0", ch0_o, 0);
        chk_eq("R1 ch1", ch1_o, 0);
        chk_eq("R1 idle", idle_o, 1);
        chk_eq("R1 lowpwr", lowpwr_o, 0);

        // R12: wake in idle does nothing
        clear_mon();
        wake_i = 1'b1; @(negedge clk); wake_i = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq("R12 wake ignored in idle sck", n_sck, 0);
        chk_eq("R12 wake ignored in idle lowpwr", lowpwr_o, 0);

        // R2, R7: first frame waveform, no result
        clear_mon();
        one_frame();
        chk_eq("R2 strobe count", n_conv, 1);
        chk_eq("R2 strobe width", conv_hi, 2 * HALF);
        chk_eq("R2 strobe to first sck", t_sck - t_conv, HALF);
        chk_eq("R2 sck edges", n_sck, FE);
        chk_eq("R2 sck high time", sck_hi, FE * HALF);
        chk_eq("R7 no valid after reset", n_valid, 0);
        chk_eq("R7 words untouched ch0", ch0_o, 0);

        // R6: second frame gives one result
        clear_mon();
        one_frame();
        chk_eq("R6 one valid per frame", n_valid, 1);
        held0 = ch0_o; held1 = ch1_o;
        repeat (30) @(negedge clk);
        chk_eq("R6 ch0 holds", ch0_o, held0);
        chk_eq("R6 ch1 holds", ch1_o, held1);

        // R8, R3, R4, R5: continuous sweep
        clear_mon();
        run_i = 1'b1;
        while (n_valid < NSW) @(negedge clk);
        run_i = 1'b0;
        wait_idle();
        chk_eq("R8 every run frame valid", n_valid, n_conv);

        // R9: nap
        clear_mon();
        held0 = ch0_o; held1 = ch1_o;
        nap_i = 1'b1; @(negedge clk); nap_i = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq("R9 nap strobes", n_conv, 2);
        chk_eq("R9 nap strobe high time", conv_hi, 2 * HALF);
        chk_eq("R9 nap sck still", n_sck, 0);
        chk_eq("R9 nap lowpwr", lowpwr_o, 1);

        // R12: start and run ignored while dormant
        clear_mon();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        run_i = 1'b1; repeat (30) @(negedge clk); run_i = 1'b0;
        chk_eq("R12 no strobe while dormant", n_conv, 0);
        chk_eq("R12 still dormant", lowpwr_o, 1);

        // R11: wake from nap
        clear_mon();
        wake_i = 1'b1; @(negedge clk); wake_i = 1'b0;
        cnt = 0;
        while (lowpwr_o) begin cnt++; @(negedge clk); end
        chk_eq("R11 nap wake length", cnt, 2 * HALF);
        chk_eq("R11 wake sck pulses", n_sck, 1);
        chk_eq("R11 wake sck high", sck_hi, HALF);
        chk_eq("R11 wake no strobe", n_conv, 0);

        // R7: first frame after wake gives nothing
        clear_mon();
        one_frame();
        chk_eq("R7 no valid after wake", n_valid, 0);
        chk_eq("R7 ch0 kept after wake", ch0_o, held0);
        chk_eq("R7 ch1 kept after wake", ch1_o, held1);
        clear_mon();
        one_frame();
        chk_eq("R7 valid resumes", n_valid, 1);

        // R10: sleep wins over nap
        clear_mon();
        sleep_i = 1'b1; nap_i = 1'b1; @(negedge clk); sleep_i = 1'b0; nap_i = 1'b0;
        repeat (40) @(negedge clk);
        chk_eq("R10 sleep strobes", n_conv, 4);
        chk_eq("R10 sleep strobe high time", conv_hi, 4 * HALF);
        chk_eq("R10 sleep sck still", n_sck, 0);

        // R11, R12: wake from sleep, start during hold-off
        clear_mon();
        wake_i = 1'b1; @(negedge clk); wake_i = 1'b0;
        cnt = 0;
        while (lowpwr_o) begin
            cnt++;
            start_i = (cnt == 10);
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk_eq("R11 sleep wake length", cnt, 2 * HALF + SETTLE);
        chk_eq("R12 start ignored in hold-off", n_conv, 0);
        chk_eq("R11 sleep wake sck pulses", n_sck, 1);

        clear_mon();
        one_frame();
        chk_eq("R7 no valid after deep wake", n_valid, 0);
        clear_mon();
        one_frame();
        chk_eq("R7 valid after deep wake", n_valid, 1);

        chk_eq("R4 12-bit timing matches", mism, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule